// File: doc/BRIEF.md
# Superscalar Decode-Stage Controller with Replay Buffer

This block sits between instruction fetch and rename in an out-of-order pipeline. Each cycle it receives a group of up to `W` instruction slots from fetch. Each slot carries flags that were computed earlier: valid, control instruction, target computed, target mispredicted, predicted taken, and a source-register count. The block passes valid slots to rename in slot order. It marks slots that have no register sources as ready to issue. When a slot shows a wrong prediction that decode can already see, it sends fetch a redirect.

Stall and squash requests come from rename, execute and commit. When a stall arrives, the block parks the arriving groups in a small FIFO of whole groups and tells fetch to hold. After the stalls clear, it replays the parked groups one per cycle, oldest first, before it returns to normal flow. A squash from commit takes priority over any stall. A squash, or a redirect raised by decode itself, discards everything that is parked.

Top module: `decode_skid_stage`

## Requirements
- R1: After synchronous reset the block forwards nothing and holds `fetch_hold`, `fetch_squash` and `fetch_mispredict` low. The first non-empty group after reset is forwarded in the same cycle.
- R2: In an active cycle, slot i is forwarded (`rn_valid[i]`=1) only if it and every lower slot are valid. Forwarding stops at the first invalid slot. `rn_tag` slice i carries the tag of a forwarded slot and is zero otherwise. All `rn_valid` bits are zero in any cycle in which nothing is forwarded.
- R3: A forwarded slot whose 2-bit source count `grp_nsrc` slice is 0 has `rn_issue_ready` set. No other slot has `rn_issue_ready` set.
- R4: Commit squash is examined before any stall. A cycle with `commit_squash` high forwards nothing and raises no fetch redirect. The block then enters a squash state, so even if a stall is also present, `fetch_hold` is low in the next cycle. Any parked groups are discarded.
- R5: When any of `rename_stall`, `exec_stall` or `commit_stall` is high in an active cycle, nothing is forwarded, the current non-empty group is parked, and `fetch_hold` goes high from the next cycle.
- R6: While blocked, every non-empty group that arrives is also parked, in arrival order, and `fetch_hold` stays high.
- R7: In the first blocked cycle with all three stalls low, `fetch_hold` is still high. The block then replays the parked groups. If nothing is parked, it returns directly to normal flow, and `fetch_hold` is low in the next cycle.
- R8: While replaying, the block forwards one parked group per cycle, oldest first, under the rules of R2, R3 and R9. It ignores the fetch inputs and keeps `fetch_hold` high. It resumes normal flow after the last parked group.
- R9: A forwarded slot that is a control instruction with its target computed and flagged mispredicted is a misprediction. So is a slot that is predicted taken but is not a control instruction. The first such slot is forwarded, and no slot above it is forwarded. In that cycle `fetch_squash` and `fetch_mispredict` are high and `fetch_redirect_pc` equals that slot's next PC. The block then enters the squash state and discards any parked groups. A mispredicted control instruction whose target is not yet computed has no effect.
- R10: In the squash state nothing is forwarded. The block leaves that state at the end of the first cycle in which both `commit_squash` and `rob_squashing` are low. While blocked, either of those inputs sends the block into the squash state and discards the parked groups.
- R11: `rob_squashing` has no effect on forwarding outside the blocked and squash states.
- R12: The parking FIFO never receives a group while it holds `DEPTH` groups, provided fetch sends at most `DEPTH` groups in total from the first stall cycle until `fetch_hold` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_valid | input | W | Per-slot valid from fetch |
| grp_ctrl | input | W | Per-slot control-instruction flag |
| grp_targ_done | input | W | Per-slot target-already-computed flag |
| grp_mispred | input | W | Per-slot computed-target-mispredicted flag |
| grp_pred_taken | input | W | Per-slot predicted-taken flag |
| grp_nsrc | input | W*2 | Per-slot source register count |
| grp_next_pc | input | W*32 | Per-slot correct next PC |
| grp_tag | input | W*8 | Per-slot instruction tag |
| rename_stall | input | 1 | Stall request from rename |
| exec_stall | input | 1 | Stall request from execute |
| commit_stall | input | 1 | Stall request from commit |
| commit_squash | input | 1 | Squash request from commit |
| rob_squashing | input | 1 | Reorder buffer squash in progress |
| rn_valid | output | W | Per-slot forwarded valid to rename |
| rn_issue_ready | output | W | Per-slot ready-to-issue mark |
| rn_tag | output | W*8 | Tags of forwarded slots |
| fetch_hold | output | 1 | Stall request to fetch |
| fetch_squash | output | 1 | Redirect squash to fetch |
| fetch_mispredict | output | 1 | Redirect cause is a misprediction |
| fetch_redirect_pc | output | 32 | Redirect target for fetch |

## Verification
Two pairs of events can land in the same cycle. The first pair is a commit squash together with a downstream stall. The bench raises both in one cycle and then checks that nothing is forwarded and that `fetch_hold` stays low in the following cycle, which shows the block did not block. The second pair is a decode-detected misprediction arriving while parked groups are being replayed. The bench parks a group with a bad slot plus a later group, releases the stall, expects a redirect on the first replay cycle, and then confirms that the later group never reaches rename and that `fetch_hold` falls.

// File: rtl/dec_pkg.sv
package dec_pkg;

    localparam int PC_W   = 32;
    localparam int TAG_W  = 8;
    localparam int NSRC_W = 2;

    typedef struct packed {
        logic              valid;
        logic              is_ctrl;
        logic              targ_done;
        logic              mispred;
        logic              pred_taken;
        logic [NSRC_W-1:0] nsrc;
        logic [PC_W-1:0]   next_pc;
        logic [TAG_W-1:0]  tag;
    } slot_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_BLOCK,
        ST_UNBLK,
        ST_SQUASH
    } dstate_e;

    // A slot whose prediction decode can already prove wrong
    function automatic logic slot_bad(slot_t s);
        return (s.is_ctrl && s.targ_done && s.mispred) ||
               (s.pred_taken && !s.is_ctrl);
    endfunction

endpackage

// File: rtl/dec_skid_fifo.sv
module dec_skid_fifo
    import dec_pkg::*;
#(
    parameter int W     = 4,
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               push,
    input  logic               pop,
    input  logic               flush,
    input  slot_t [W-1:0]      din,
    output slot_t [W-1:0]      head,
    output logic [CNT_W-1:0]   count
);

    slot_t [W-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= bump(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign head = mem[rd_ptr];

endmodule

// File: rtl/dec_slot_scan.sv
module dec_slot_scan
    import dec_pkg::*;
#(
    parameter int W = 4
) (
    input  logic               en,
    input  slot_t [W-1:0]      grp,
    output logic [W-1:0]       fwd,
    output logic [W-1:0]       ready,
    output logic [W*TAG_W-1:0] tags,
    output logic               redirect,
    output logic [PC_W-1:0]    redirect_pc
);

    always_comb begin
        logic alive;
        alive       = en;
        fwd         = '0;
        ready       = '0;
        tags        = '0;
        redirect    = 1'b0;
        redirect_pc = '0;
        for (int i = 0; i < W; i++) begin
            if (alive && grp[i].valid) begin
                fwd[i]                 = 1'b1;
                ready[i]               = (grp[i].nsrc == '0);
                tags[i*TAG_W +: TAG_W] = grp[i].tag;
                if (slot_bad(grp[i])) begin
                    redirect    = 1'b1;
                    redirect_pc = grp[i].next_pc;
                    alive       = 1'b0;
                end
            end else begin
                alive = 1'b0;
            end
        end
    end

endmodule

// File: rtl/decode_skid_stage.sv
module decode_skid_stage
    import dec_pkg::*;
#(
    parameter int W     = 4,
    parameter int DEPTH = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [W-1:0]         grp_valid,
    input  logic [W-1:0]         grp_ctrl,
    input  logic [W-1:0]         grp_targ_done,
    input  logic [W-1:0]         grp_mispred,
    input  logic [W-1:0]         grp_pred_taken,
    input  logic [W*NSRC_W-1:0]  grp_nsrc,
    input  logic [W*PC_W-1:0]    grp_next_pc,
    input  logic [W*TAG_W-1:0]   grp_tag,
    input  logic                 rename_stall,
    input  logic                 exec_stall,
    input  logic                 commit_stall,
    input  logic                 commit_squash,
    input  logic                 rob_squashing,
    output logic [W-1:0]         rn_valid,
    output logic [W-1:0]         rn_issue_ready,
    output logic [W*TAG_W-1:0]   rn_tag,
    output logic                 fetch_hold,
    output logic                 fetch_squash,
    output logic                 fetch_mispredict,
    output logic [PC_W-1:0]      fetch_redirect_pc
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    dstate_e          state, nstate;
    slot_t [W-1:0]    fg;
    slot_t [W-1:0]    head;
    slot_t [W-1:0]    src;
    logic [CNT_W-1:0] skid_cnt;
    logic             skid_push, skid_pop, skid_flush;
    logic             any_stall, active, scan_en, fg_busy;
    logic             redirect;
    logic [PC_W-1:0]  redirect_pc;

    // Pack the flat fetch ports into slot records
    for (genvar g = 0; g < W; g++) begin : g_pack
        assign fg[g] = '{valid:      grp_valid[g],
                         is_ctrl:    grp_ctrl[g],
                         targ_done:  grp_targ_done[g],
                         mispred:    grp_mispred[g],
                         pred_taken: grp_pred_taken[g],
                         nsrc:       grp_nsrc[g*NSRC_W +: NSRC_W],
                         next_pc:    grp_next_pc[g*PC_W +: PC_W],
                         tag:        grp_tag[g*TAG_W +: TAG_W]};
    end

    assign any_stall = rename_stall | exec_stall | commit_stall;
    assign active    = (state == ST_IDLE) || (state == ST_RUN) || (state == ST_UNBLK);
    assign scan_en   = active && !commit_squash && !any_stall;
    assign fg_busy   = |grp_valid;
    assign src       = (state == ST_UNBLK) ? head : fg;

    dec_slot_scan #(.W(W)) u_scan (
        .en          (scan_en),
        .grp         (src),
        .fwd         (rn_valid),
        .ready       (rn_issue_ready),
        .tags        (rn_tag),
        .redirect    (redirect),
        .redirect_pc (redirect_pc)
    );

    assign skid_push = fg_busy &&
        ((active && state != ST_UNBLK && !commit_squash && any_stall) ||
         (state == ST_BLOCK && !commit_squash && !rob_squashing));
    assign skid_pop   = (state == ST_UNBLK) && scan_en && !redirect;
    assign skid_flush = (active && commit_squash) || redirect ||
                        (state == ST_BLOCK && (commit_squash || rob_squashing));

    dec_skid_fifo #(.W(W), .DEPTH(DEPTH)) u_skid (
        .clk   (clk),
        .rst   (rst),
        .push  (skid_push),
        .pop   (skid_pop),
        .flush (skid_flush),
        .din   (fg),
        .head  (head),
        .count (skid_cnt)
    );

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE, ST_RUN, ST_UNBLK: begin
                if (commit_squash)           nstate = ST_SQUASH;
                else if (any_stall)          nstate = ST_BLOCK;
                else if (redirect)           nstate = ST_SQUASH;
                else if (state == ST_UNBLK) begin
                    if (skid_cnt == CNT_W'(1)) nstate = ST_RUN;
                end else if (|rn_valid)      nstate = ST_RUN;
            end
            ST_BLOCK: begin
                if (commit_squash || rob_squashing) nstate = ST_SQUASH;
                else if (!any_stall)
                    nstate = (skid_cnt == '0 && !skid_push) ? ST_RUN : ST_UNBLK;
            end
            ST_SQUASH: begin
                if (!commit_squash && !rob_squashing) nstate = ST_RUN;
            end
            default: nstate = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nstate;
    end

    assign fetch_hold        = (state == ST_BLOCK) || (state == ST_UNBLK);
    assign fetch_squash      = redirect;
    assign fetch_mispredict  = redirect;
    assign fetch_redirect_pc = redirect_pc;

endmodule

// File: rtl/dec_stage_chk.sv
module dec_stage_chk #(
    parameter int W     = 4,
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             rename_stall,
    input logic             exec_stall,
    input logic             commit_stall,
    input logic             commit_squash,
    input logic [W-1:0]     rn_valid,
    input logic [W-1:0]     rn_issue_ready,
    input logic             fetch_squash,
    input logic             skid_push,
    input logic [CNT_W-1:0] skid_cnt
);

    // R4
    squash_first_chk: assert property (@(posedge clk) disable iff (rst)
        commit_squash |-> rn_valid == '0);

    // R5
    stall_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (rename_stall || exec_stall || commit_stall) |-> rn_valid == '0);

    // R2
    contig_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        (rn_valid & W'(rn_valid + 1'b1)) == '0);

    // R3
    ready_sub_chk: assert property (@(posedge clk) disable iff (rst)
        (rn_issue_ready & ~rn_valid) == '0);

    // R10
    redirect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_squash |=> rn_valid == '0);

    // R12
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        skid_push |-> skid_cnt < CNT_W'(DEPTH));

    // R12
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        skid_cnt <= CNT_W'(DEPTH));

endmodule

bind decode_skid_stage dec_stage_chk #(.W(W), .DEPTH(DEPTH)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .rename_stall   (rename_stall),
    .exec_stall     (exec_stall),
    .commit_stall   (commit_stall),
    .commit_squash  (commit_squash),
    .rn_valid       (rn_valid),
    .rn_issue_ready (rn_issue_ready),
    .fetch_squash   (fetch_squash),
    .skid_push      (skid_push),
    .skid_cnt       (skid_cnt)
);

// File: tb/sim_decode_skid_stage.sv
module sim_decode_skid_stage;

    localparam int W     = 4;
    localparam int DEPTH = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [W-1:0]    grp_valid, grp_ctrl, grp_targ_done, grp_mispred, grp_pred_taken;
    logic [W*2-1:0]  grp_nsrc;
    logic [W*32-1:0] grp_next_pc;
    logic [W*8-1:0]  grp_tag;
    logic rename_stall, exec_stall, commit_stall, commit_squash, rob_squashing;
    logic [W-1:0]    rn_valid, rn_issue_ready;
    logic [W*8-1:0]  rn_tag;
    logic            fetch_hold, fetch_squash, fetch_mispredict;
    logic [31:0]     fetch_redirect_pc;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 0;

    decode_skid_stage #(.W(W), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst),
        .grp_valid(grp_valid), .grp_ctrl(grp_ctrl), .grp_targ_done(grp_targ_done),
        .grp_mispred(grp_mispred), .grp_pred_taken(grp_pred_taken),
        .grp_nsrc(grp_nsrc), .grp_next_pc(grp_next_pc), .grp_tag(grp_tag),
        .rename_stall(rename_stall), .exec_stall(exec_stall),
        .commit_stall(commit_stall), .commit_squash(commit_squash),
        .rob_squashing(rob_squashing),
        .rn_valid(rn_valid), .rn_issue_ready(rn_issue_ready), .rn_tag(rn_tag),
        .fetch_hold(fetch_hold), .fetch_squash(fetch_squash),
        .fetch_mispredict(fetch_mispredict), .fetch_redirect_pc(fetch_redirect_pc)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_in();
        grp_valid = '0; grp_ctrl = '0; grp_targ_done = '0; grp_mispred = '0;
        grp_pred_taken = '0; grp_nsrc = '0; grp_next_pc = '0; grp_tag = '0;
        rename_stall = 0; exec_stall = 0; commit_stall = 0;
        commit_squash = 0; rob_squashing = 0;
    endtask

    // kind: 0 clean, 1 computed-target mispredict, 2 taken non-control, 3 mispredict flag without computed target
    task automatic load(input logic [3:0] vm, input int base, input int bp, input int kind);
        for (int i = 0; i < W; i++) begin
            grp_valid[i]          = vm[i];
            grp_tag[i*8 +: 8]     = 8'(base + i);
            grp_next_pc[i*32 +: 32] = 32'(base * 256 + i * 4);
            grp_nsrc[i*2 +: 2]    = 2'(base + i);
            grp_ctrl[i]           = (i % 2 == 1);
            grp_targ_done[i]      = (i % 2 == 1);
            grp_mispred[i]        = 1'b0;
            grp_pred_taken[i]     = 1'b0;
            if (i == bp) begin
                case (kind)
                    1: begin grp_ctrl[i] = 1; grp_targ_done[i] = 1; grp_mispred[i] = 1; end
                    2: begin grp_ctrl[i] = 0; grp_targ_done[i] = 0; grp_pred_taken[i] = 1; end
                    3: begin grp_ctrl[i] = 1; grp_targ_done[i] = 0; grp_mispred[i] = 1; end
                    default: ;
                endcase
            end
        end
    endtask

    function automatic logic [3:0] exp_mask(logic [3:0] vm, int bp, int kind);
        logic [3:0] m = '0;
        for (int i = 0; i < W; i++) begin
            if (!vm[i]) break;
            m[i] = 1'b1;
            if (i == bp && (kind == 1 || kind == 2)) break;
        end
        return m;
    endfunction

    task automatic check_group(input string req, input logic [3:0] vm, input int base,
                               input int bp, input int kind);
        logic [3:0]  m;
        logic [31:0] et;
        logic [3:0]  er;
        logic        redir;
        m = exp_mask(vm, bp, kind);
        et = '0; er = '0;
        for (int i = 0; i < W; i++) begin
            if (m[i]) begin
                et[i*8 +: 8] = 8'(base + i);
                er[i] = (((base + i) % 4) == 0);
            end
        end
        redir = (kind == 1 || kind == 2) && bp >= 0 && m[bp];
        chk({req, " fwd"},    64'(rn_valid), 64'(m));
        chk({req, " tag"},    64'(rn_tag), 64'(et));
        chk({req, " ready"},  64'(rn_issue_ready), 64'(er));
        chk({req, " squash"}, 64'(fetch_squash), 64'(redir));
        chk({req, " mispr"},  64'(fetch_mispredict), 64'(redir));
        if (redir) chk({req, " pc"}, 64'(fetch_redirect_pc), 64'(base * 256 + bp * 4));
    endtask

    task automatic nxt();
        @(negedge clk);
        clear_in();
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        clear_in();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1 reset state
        chk("R1 fwd",    64'(rn_valid), 0);
        chk("R1 hold",   64'(fetch_hold), 0);
        chk("R1 squash", 64'(fetch_squash), 0);
        chk("R1 mispr",  64'(fetch_mispredict), 0);
        nxt(); load(4'hF, 200, -1, 0); #1;
        check_group("R1 first group", 4'hF, 200, -1, 0);

        // R2 R3 sweep over every valid pattern
        for (int v = 0; v < 16; v++) begin
            nxt(); load(4'(v), v * 4, -1, 0); #1;
            check_group("R2 R3 sweep", 4'(v), v * 4, -1, 0);
            chk("R2 hold", 64'(fetch_hold), 0);
        end

        // R9 R10 mispredict sweep
        for (int k = 1; k <= 3; k++) begin
            for (int p = 0; p < W; p++) begin
                nxt(); load(4'hF, 70 + p, p, k); #1;
                check_group("R9 redirect", 4'hF, 70 + p, p, k);
                if (k != 3) begin
                    nxt(); load(4'hF, 90, -1, 0); #1;
                    chk("R10 squash state fwd", 64'(rn_valid), 0);
                end
                nxt(); load(4'hF, 95, -1, 0); #1;
                check_group("R9 resume", 4'hF, 95, -1, 0);
            end
        end
        // R9 bad slot beyond an empty slot is not reached
        nxt(); load(4'b0011, 60, 2, 1); #1;
        check_group("R9 unreached", 4'b0011, 60, 2, 1);

        // R4 R10 commit squash sequence
        nxt(); load(4'hF, 10, -1, 0); commit_squash = 1; #1;
        chk("R4 fwd", 64'(rn_valid), 0);
        chk("R4 no redirect", 64'(fetch_squash), 0);
        nxt(); load(4'hF, 11, -1, 0); commit_squash = 1; #1;
        chk("R10 cs hold", 64'(rn_valid), 0);
        nxt(); load(4'hF, 12, -1, 0); rob_squashing = 1; #1;
        chk("R10 rob hold", 64'(rn_valid), 0);
        nxt(); load(4'hF, 13, -1, 0); #1;
        chk("R10 exit cycle", 64'(rn_valid), 0);
        nxt(); load(4'hF, 14, -1, 0); #1;
        check_group("R10 running", 4'hF, 14, -1, 0);

        // R11 rob squashing ignored while running
        nxt(); load(4'hF, 15, -1, 0); rob_squashing = 1; #1;
        check_group("R11 rob ignored", 4'hF, 15, -1, 0);

        // R5 R6 R7 R8 stall and replay
        nxt(); load(4'hF, 100, -1, 0); rename_stall = 1; #1;
        chk("R5 fwd", 64'(rn_valid), 0);
        chk("R5 hold first", 64'(fetch_hold), 0);
        nxt(); load(4'b0011, 110, -1, 0); rename_stall = 1; #1;
        chk("R6 fwd", 64'(rn_valid), 0);
        chk("R5 hold", 64'(fetch_hold), 1);
        nxt(); exec_stall = 1; #1;
        chk("R6 hold", 64'(fetch_hold), 1);
        nxt(); #1;
        chk("R7 hold", 64'(fetch_hold), 1);
        chk("R7 fwd", 64'(rn_valid), 0);
        nxt(); load(4'hF, 120, -1, 0); #1;
        check_group("R8 replay first", 4'hF, 100, -1, 0);
        chk("R8 hold", 64'(fetch_hold), 1);
        nxt(); #1;
        check_group("R8 replay second", 4'b0011, 110, -1, 0);
        nxt(); #1;
        chk("R8 done hold", 64'(fetch_hold), 0);
        chk("R8 fetch ignored", 64'(rn_valid), 0);
        nxt(); load(4'hF, 130, -1, 0); #1;
        check_group("R8 running", 4'hF, 130, -1, 0);

        // R10 squash while blocked drops parked groups
        nxt(); load(4'hF, 140, -1, 0); commit_stall = 1; #1;
        chk("R5 commit stall", 64'(rn_valid), 0);
        nxt(); commit_stall = 1; rob_squashing = 1; #1;
        chk("R10 blk squash", 64'(rn_valid), 0);
        nxt(); #1;
        chk("R10 exit", 64'(rn_valid), 0);
        chk("R10 hold", 64'(fetch_hold), 0);
        nxt(); #1;
        chk("R10 no replay", 64'(rn_valid), 0);
        chk("R10 no replay hold", 64'(fetch_hold), 0);

        // R7 blocked with nothing parked
        nxt(); exec_stall = 1; #1;
        nxt(); #1;
        chk("R7 empty hold", 64'(fetch_hold), 1);
        nxt(); load(4'hF, 150, -1, 0); #1;
        chk("R7 direct run hold", 64'(fetch_hold), 0);
        check_group("R7 direct run", 4'hF, 150, -1, 0);

        // R4 squash and stall together
        nxt(); load(4'hF, 160, -1, 0); commit_squash = 1; rename_stall = 1; #1;
        chk("R4 both fwd", 64'(rn_valid), 0);
        nxt(); #1;
        chk("R4 not blocked", 64'(fetch_hold), 0);
        nxt(); #1;
        chk("R4 nothing parked", 64'(fetch_hold), 0);
        chk("R4 nothing replayed", 64'(rn_valid), 0);

        // R9 mispredict during replay flushes the rest
        nxt(); load(4'hF, 170, 1, 1); rename_stall = 1; #1;
        nxt(); load(4'hF, 180, -1, 0); rename_stall = 1; #1;
        nxt(); #1;
        nxt(); #1;
        check_group("R9 replay redirect", 4'hF, 170, 1, 1);
        nxt(); #1;
        chk("R9 squash state", 64'(rn_valid), 0);
        chk("R9 squash hold", 64'(fetch_hold), 0);
        nxt(); #1;
        nxt(); #1;
        chk("R9 flushed", 64'(rn_valid), 0);
        chk("R9 flushed hold", 64'(fetch_hold), 0);

        // R12 fill to DEPTH and replay in order
        nxt(); load(4'hF, 20, -1, 0); commit_stall = 1; #1;
        for (int g = 1; g < DEPTH; g++) begin
            nxt(); load(4'hF, 20 + g * 4, -1, 0); commit_stall = 1; #1;
            chk("R6 R12 hold", 64'(fetch_hold), 1);
        end
        nxt(); #1;
        for (int g = 0; g < DEPTH; g++) begin
            nxt(); #1;
            check_group("R12 R8 replay order", 4'hF, 20 + g * 4, -1, 0);
            chk("R12 hold", 64'(fetch_hold), 1);
        end
        nxt(); #1;
        chk("R12 drained", 64'(fetch_hold), 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule